// File: doc/BRIEF.md
# Load Queue with Store-Ordering Violation Detection

This block keeps the in-flight loads of an out-of-order core in a circular queue in program order, and it tracks the fill level of a companion store queue. When a load enters the queue, the block reports the slot the load takes and the store-queue tail at that moment. If the store queue is empty, it reports a "no older store" flag. When a store enters, the block reports the current load-queue tail. That position marks the first load that is younger than the store.

When a store's address resolves, the caller presents the load position that the store recorded, together with the store address. In one cycle the block compares that address against every younger load that has already produced an address. The comparison works on aligned 256-byte blocks. The oldest match is latched as the pending ordering violator and a fault is raised. A read pulse hands the violator to the caller and clears the register.

The queue retires loads in order from the head against a youngest-committed sequence number. A squash trims younger loads from the tail. The squash also drops the stalled-load record when that load is removed, and it drops the blocked-load record when the squash number is older than the blocked load. A free-entry count combines both queues for dispatch throttling.

Top module: `lq_order_unit`

## Requirements
- R1: A load insert is accepted when `ld_count` is below LQ_DEPTH-1 and no squash is presented in that cycle. The load takes slot `ld_ins_lq_idx`, which equals the load tail. While the store count is nonzero, `ld_ins_sq_idx` gives the store tail and `ld_ins_sq_none` is 0. With no stores present, `ld_ins_sq_none` is 1. A rejected insert leaves `ld_count` unchanged.
- R2: A store insert is accepted while `st_count` is below SQ_DEPTH-1. In the same cycle, `st_ins_lq_idx` shows the current load tail. `st_release` lowers `st_count` by one when it is nonzero.
- R3: `st_exec_fault` rises in the same cycle as `st_exec_valid` when some live, executed load in the ring from `st_exec_lq_idx` up to (not including) the load tail matches the store. A match means that the load address and the store address are equal once the low 8 bits are dropped. Addresses that differ in bit 8 or above never match.
- R4: When a store check finds a match, from the next cycle on `viol_valid` is 1 and `viol_lq_idx`/`viol_seq` name the matching load nearest to `st_exec_lq_idx`. A check that finds no match leaves `viol_valid` at 0.
- R5: While `viol_valid` is 1, a store check performs no scan, raises no fault and leaves the violator unchanged.
- R6: `viol_read` while `viol_valid` is 1 leaves the violator visible in that cycle and clears `viol_valid` from the next cycle.
- R7: Loads that have not executed never match. Loads older than the store's recorded position never match.
- R8: `commit_valid` retires, in one cycle, the unbroken run of head loads whose sequence number is at most `commit_seq`. A load insert in the same cycle is still accepted.
- R9: `squash_valid` removes the unbroken run of tail loads whose sequence number is greater than `squash_seq` and pulls the load tail back by that many slots. A load insert or a commit presented in the same cycle is ignored.
- R10: A squash that removes the slot held in the stall record clears `stalled`. A squash with `squash_seq` below the recorded blocked sequence number clears `blocked`. Any other squash leaves both records as they are.
- R11: `free_entries` = min(LQ_DEPTH-`ld_count`, SQ_DEPTH-`st_count`) - 1.
- R12: After reset both counts are 0, both tails are 0, `viol_valid`, `stalled` and `blocked` are 0, and `free_entries` is min(LQ_DEPTH, SQ_DEPTH) - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_ins_valid | input | 1 | Insert a load |
| ld_ins_seq | input | SEQ_W | Sequence number of the inserted load |
| ld_ins_ok | output | 1 | A load insert would be accepted this cycle |
| ld_ins_lq_idx | output | log2(LQ_DEPTH) | Slot the inserted load takes |
| ld_ins_sq_idx | output | log2(SQ_DEPTH) | Store tail recorded by the load |
| ld_ins_sq_none | output | 1 | No store older than the load is present |
| st_ins_valid | input | 1 | Insert a store |
| st_ins_ok | output | 1 | A store insert would be accepted this cycle |
| st_ins_sq_idx | output | log2(SQ_DEPTH) | Store slot taken |
| st_ins_lq_idx | output | log2(LQ_DEPTH) | Load tail recorded by the store |
| st_release | input | 1 | Free the oldest store-queue entry |
| ld_exec_valid | input | 1 | A load has produced its effective address |
| ld_exec_idx | input | log2(LQ_DEPTH) | Slot of that load |
| ld_exec_addr | input | ADDR_W | Effective address of that load |
| st_exec_valid | input | 1 | A store address is resolved; run the check |
| st_exec_lq_idx | input | log2(LQ_DEPTH) | Load position the store recorded |
| st_exec_addr | input | ADDR_W | Store effective address |
| st_exec_fault | output | 1 | Ordering violation found this cycle |
| viol_read | input | 1 | Take the latched violator and clear it |
| viol_valid | output | 1 | A violator is latched |
| viol_lq_idx | output | log2(LQ_DEPTH) | Slot of the violating load |
| viol_seq | output | SEQ_W | Sequence number of the violating load |
| commit_valid | input | 1 | Retire loads against `commit_seq` |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash loads younger than `squash_seq` |
| squash_seq | input | SEQ_W | Squash boundary |
| stall_set | input | 1 | Record a stalled load |
| stall_lq_idx | input | log2(LQ_DEPTH) | Slot of the stalled load |
| stalled | output | 1 | Stall record present |
| blk_set | input | 1 | Record a blocked load |
| blk_seq | input | SEQ_W | Sequence number of the blocked load |
| blocked | output | 1 | Blocked record present |
| ld_count | output | log2(LQ_DEPTH+1) | Loads held |
| st_count | output | log2(SQ_DEPTH+1) | Stores held |
| free_entries | output | log2(max depth+1) | Combined free slots |

## Verification
Some results are combinational from the current state and inputs: the insert positions, `ld_ins_ok`, `st_exec_fault` and `free_entries`. The bench drives inputs just after a falling edge and reads these one time step later, before the rising edge. Every registered result (counts, violator, stall and blocked records) is due exactly one rising edge after its stimulus, so the bench reads it at the following falling edge. A run of many retirements or squashed loads completes in that single edge. The violator sweep moves the ring through every wrap offset and combines executed-matching, executed-nonmatching and unexecuted states for each younger load. For each combination the expected oldest match is worked out arithmetically.

// File: rtl/lq_pkg.sv
// Shared constants and helpers for the load-queue ordering block.
package lq_pkg;

    // Default address granularity of the ordering check: 256-byte blocks.
    localparam int unsigned LQ_BLK_SHIFT_DEF = 8;

    // Larger of two unsigned values, used for width derivation.
    function automatic int unsigned lq_umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lq_lead_count.sv
// Counts the unbroken run of ones starting at bit 0 of a vector.
// Used for commit runs, squash runs and (on an inverted vector) to find
// the position of the oldest match. Purely combinational.
module lq_lead_count #(
    parameter int unsigned N  = 8,
    localparam int unsigned CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] cnt
);

    // Walk from bit 0 and stop counting at the first zero.
    always_comb begin
        logic run;
        run = 1'b1;
        cnt = '0;
        for (int k = 0; k < N; k++) begin
            if (run && vec[k]) begin
                cnt = cnt + 1'b1;
            end else begin
                run = 1'b0;
            end
        end
    end

endmodule

// File: rtl/lq_store_track.sv
// Tail pointer and occupancy of the companion store queue.
// Assumes DEPTH is a power of two; one slot stays reserved, so at most
// DEPTH-1 stores are held. A release with nothing held is ignored.
module lq_store_track #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_req,
    input  logic          rel_req,
    output logic          ins_ok,
    output logic [IW-1:0] tail,
    output logic [CW-1:0] count
);

    logic ins_go;
    logic rel_go;

    assign ins_ok = (count < CW'(DEPTH - 1));
    assign ins_go = ins_req && ins_ok;
    assign rel_go = rel_req && (count != '0);

    // Advance the tail on insert and keep the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail  <= '0;
            count <= '0;
        end else begin
            if (ins_go) begin
                tail <= tail + 1'b1;
            end
            count <= count + CW'(ins_go) - CW'(rel_go);
        end
    end

endmodule

// File: rtl/lq_order_unit.sv
// Circular load queue with a single-cycle store-to-load ordering check.
// Assumes LQ_DEPTH and SQ_DEPTH are powers of two, BLK_SHIFT < ADDR_W,
// sequence numbers rise monotonically without wrap, and a store's
// recorded load position is never behind the load tail (a squash that
// reaches past it also removes the store). One slot is kept free.
module lq_order_unit
    import lq_pkg::*;
#(
    parameter int unsigned LQ_DEPTH  = 8,
    parameter int unsigned SQ_DEPTH  = 8,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned SEQ_W     = 8,
    parameter int unsigned BLK_SHIFT = LQ_BLK_SHIFT_DEF,
    localparam int unsigned LQ_IDX_W = $clog2(LQ_DEPTH),
    localparam int unsigned SQ_IDX_W = $clog2(SQ_DEPTH),
    localparam int unsigned LQ_CNT_W = $clog2(LQ_DEPTH + 1),
    localparam int unsigned SQ_CNT_W = $clog2(SQ_DEPTH + 1),
    localparam int unsigned FREE_W   = $clog2(lq_umax(LQ_DEPTH, SQ_DEPTH) + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_ins_valid,
    input  logic [SEQ_W-1:0]    ld_ins_seq,
    output logic                ld_ins_ok,
    output logic [LQ_IDX_W-1:0] ld_ins_lq_idx,
    output logic [SQ_IDX_W-1:0] ld_ins_sq_idx,
    output logic                ld_ins_sq_none,
    input  logic                st_ins_valid,
    output logic                st_ins_ok,
    output logic [SQ_IDX_W-1:0] st_ins_sq_idx,
    output logic [LQ_IDX_W-1:0] st_ins_lq_idx,
    input  logic                st_release,
    input  logic                ld_exec_valid,
    input  logic [LQ_IDX_W-1:0] ld_exec_idx,
    input  logic [ADDR_W-1:0]   ld_exec_addr,
    input  logic                st_exec_valid,
    input  logic [LQ_IDX_W-1:0] st_exec_lq_idx,
    input  logic [ADDR_W-1:0]   st_exec_addr,
    output logic                st_exec_fault,
    input  logic                viol_read,
    output logic                viol_valid,
    output logic [LQ_IDX_W-1:0] viol_lq_idx,
    output logic [SEQ_W-1:0]    viol_seq,
    input  logic                commit_valid,
    input  logic [SEQ_W-1:0]    commit_seq,
    input  logic                squash_valid,
    input  logic [SEQ_W-1:0]    squash_seq,
    input  logic                stall_set,
    input  logic [LQ_IDX_W-1:0] stall_lq_idx,
    output logic                stalled,
    input  logic                blk_set,
    input  logic [SEQ_W-1:0]    blk_seq,
    output logic                blocked,
    output logic [LQ_CNT_W-1:0] ld_count,
    output logic [SQ_CNT_W-1:0] st_count,
    output logic [FREE_W-1:0]   free_entries
);

    // ---------------- load-queue state ----------------
    logic [LQ_IDX_W-1:0]              head_q;
    logic [LQ_IDX_W-1:0]              tail_q;
    logic [LQ_CNT_W-1:0]              cnt_q;
    logic [LQ_DEPTH-1:0]              live_q;
    logic [LQ_DEPTH-1:0]              known_q;
    logic [LQ_DEPTH-1:0][ADDR_W-1:0]  addr_q;
    logic [LQ_DEPTH-1:0][SEQ_W-1:0]   seq_q;

    logic                viol_valid_q;
    logic [LQ_IDX_W-1:0] viol_idx_q;
    logic [SEQ_W-1:0]    viol_seq_q;

    logic                stalled_q;
    logic [LQ_IDX_W-1:0] stall_idx_q;
    logic                blocked_q;
    logic [SEQ_W-1:0]    blk_seq_q;

    // ---------------- store-queue tracking ----------------
    logic [SQ_IDX_W-1:0] sq_tail;
    logic [SQ_CNT_W-1:0] sq_cnt;

    lq_store_track #(
        .DEPTH (SQ_DEPTH)
    ) u_sq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ins_req (st_ins_valid),
        .rel_req (st_release),
        .ins_ok  (st_ins_ok),
        .tail    (sq_tail),
        .count   (sq_cnt)
    );

    // ---------------- insert positions ----------------
    logic ins_go;

    assign ld_ins_ok      = (cnt_q < LQ_CNT_W'(LQ_DEPTH - 1)) && !squash_valid;
    assign ins_go         = ld_ins_valid && ld_ins_ok;
    assign ld_ins_lq_idx  = tail_q;
    assign ld_ins_sq_idx  = sq_tail;
    assign ld_ins_sq_none = (sq_cnt == '0);
    assign st_ins_sq_idx  = sq_tail;
    assign st_ins_lq_idx  = tail_q;

    // ---------------- commit run from the head ----------------
    logic [LQ_DEPTH-1:0] cm_vec;
    logic [LQ_CNT_W-1:0] cm_n;

    // Mark head-relative entries that are old enough to retire.
    always_comb begin
        for (int k = 0; k < LQ_DEPTH; k++) begin
            cm_vec[k] = commit_valid && (LQ_CNT_W'(k) < cnt_q) &&
                        (seq_q[head_q + LQ_IDX_W'(k)] <= commit_seq);
        end
    end

    lq_lead_count #(
        .N (LQ_DEPTH)
    ) u_cm_run (
        .vec (cm_vec),
        .cnt (cm_n)
    );

    // ---------------- squash run from the tail ----------------
    logic [LQ_DEPTH-1:0] sq_vec;
    logic [LQ_CNT_W-1:0] sq_n;

    // Mark tail-relative entries younger than the squash boundary.
    always_comb begin
        for (int k = 0; k < LQ_DEPTH; k++) begin
            sq_vec[k] = squash_valid && (LQ_CNT_W'(k) < cnt_q) &&
                        (seq_q[tail_q - LQ_IDX_W'(k + 1)] > squash_seq);
        end
    end

    lq_lead_count #(
        .N (LQ_DEPTH)
    ) u_sq_run (
        .vec (sq_vec),
        .cnt (sq_n)
    );

    // ---------------- ordering scan ----------------
    logic [LQ_IDX_W-1:0] scan_span;
    logic [LQ_DEPTH-1:0] hit_vec;
    logic [LQ_CNT_W-1:0] first_pos;
    logic                scan_hit;
    logic [LQ_IDX_W-1:0] viol_slot;

    assign scan_span = tail_q - st_exec_lq_idx;

    // Compare every younger, executed load against the store's block.
    always_comb begin
        for (int k = 0; k < LQ_DEPTH; k++) begin
            hit_vec[k] = (LQ_IDX_W'(k) < scan_span) &&
                         live_q[st_exec_lq_idx + LQ_IDX_W'(k)] &&
                         known_q[st_exec_lq_idx + LQ_IDX_W'(k)] &&
                         ((addr_q[st_exec_lq_idx + LQ_IDX_W'(k)] >> BLK_SHIFT) ==
                          (st_exec_addr >> BLK_SHIFT));
        end
    end

    lq_lead_count #(
        .N (LQ_DEPTH)
    ) u_first (
        .vec (~hit_vec),
        .cnt (first_pos)
    );

    assign scan_hit      = |hit_vec;
    assign viol_slot     = st_exec_lq_idx + LQ_IDX_W'(first_pos);
    assign st_exec_fault = st_exec_valid && !viol_valid_q && scan_hit;

    // ---------------- queue update ----------------
    // Apply squash, or else commit and insert, plus address capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            cnt_q   <= '0;
            live_q  <= '0;
            known_q <= '0;
            addr_q  <= '0;
            seq_q   <= '0;
        end else begin
            if (squash_valid) begin
                for (int k = 0; k < LQ_DEPTH; k++) begin
                    if (LQ_CNT_W'(k) < sq_n) begin
                        live_q[tail_q - LQ_IDX_W'(k + 1)] <= 1'b0;
                    end
                end
                tail_q <= tail_q - LQ_IDX_W'(sq_n);
                cnt_q  <= cnt_q - sq_n;
            end else begin
                for (int k = 0; k < LQ_DEPTH; k++) begin
                    if (LQ_CNT_W'(k) < cm_n) begin
                        live_q[head_q + LQ_IDX_W'(k)] <= 1'b0;
                    end
                end
                head_q <= head_q + LQ_IDX_W'(cm_n);
                if (ins_go) begin
                    live_q[tail_q]  <= 1'b1;
                    known_q[tail_q] <= 1'b0;
                    seq_q[tail_q]   <= ld_ins_seq;
                    tail_q          <= tail_q + 1'b1;
                end
                cnt_q <= cnt_q - cm_n + LQ_CNT_W'(ins_go);
            end
            if (ld_exec_valid && live_q[ld_exec_idx]) begin
                known_q[ld_exec_idx] <= 1'b1;
                addr_q[ld_exec_idx]  <= ld_exec_addr;
            end
        end
    end

    // ---------------- violator register ----------------
    // Latch the oldest match once; a read hands it over and clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_valid_q <= 1'b0;
            viol_idx_q   <= '0;
            viol_seq_q   <= '0;
        end else if (viol_valid_q) begin
            if (viol_read) begin
                viol_valid_q <= 1'b0;
            end
        end else if (st_exec_valid) begin
            viol_valid_q <= scan_hit;
            viol_idx_q   <= viol_slot;
            viol_seq_q   <= seq_q[viol_slot];
        end
    end

    // ---------------- stall and blocked records ----------------
    logic [LQ_IDX_W-1:0] stall_back;
    logic                stall_gone;

    assign stall_back = tail_q - LQ_IDX_W'(1) - stall_idx_q;
    assign stall_gone = (LQ_CNT_W'(stall_back) < sq_n);

    // Set the stall record, or drop it when its load is squashed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stalled_q   <= 1'b0;
            stall_idx_q <= '0;
        end else if (stall_set) begin
            stalled_q   <= 1'b1;
            stall_idx_q <= stall_lq_idx;
        end else if (squash_valid && stalled_q && stall_gone) begin
            stalled_q <= 1'b0;
        end
    end

    // Set the blocked record, or drop it on a squash older than it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked_q <= 1'b0;
            blk_seq_q <= '0;
        end else if (blk_set) begin
            blocked_q <= 1'b1;
            blk_seq_q <= blk_seq;
        end else if (squash_valid && blocked_q && (squash_seq < blk_seq_q)) begin
            blocked_q <= 1'b0;
        end
    end

    // ---------------- free entries and outputs ----------------
    logic [FREE_W-1:0] lq_free;
    logic [FREE_W-1:0] sq_free;

    assign lq_free      = FREE_W'(LQ_DEPTH) - FREE_W'(cnt_q);
    assign sq_free      = FREE_W'(SQ_DEPTH) - FREE_W'(sq_cnt);
    assign free_entries = ((lq_free < sq_free) ? lq_free : sq_free) - 1'b1;

    assign viol_valid  = viol_valid_q;
    assign viol_lq_idx = viol_idx_q;
    assign viol_seq    = viol_seq_q;
    assign stalled     = stalled_q;
    assign blocked     = blocked_q;
    assign ld_count    = cnt_q;
    assign st_count    = sq_cnt;

endmodule

// File: rtl/lq_order_unit_chk.sv
// Temporal properties of the load-queue ordering block, observed on its
// ports. Attached to every instance of the top module by bind.
module lq_order_unit_chk #(
    parameter int unsigned LQ_DEPTH = 8,
    parameter int unsigned LQ_IDX_W = 3,
    parameter int unsigned LQ_CNT_W = 4,
    parameter int unsigned FREE_W   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                st_exec_fault,
    input logic                viol_read,
    input logic                viol_valid,
    input logic [LQ_IDX_W-1:0] viol_lq_idx,
    input logic                squash_valid,
    input logic [LQ_CNT_W-1:0] ld_count,
    input logic [FREE_W-1:0]   free_entries
);

    AST_FAULT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        st_exec_fault |=> viol_valid); // R4

    AST_HELD_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> !st_exec_fault); // R5

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && !viol_read) |=> (viol_valid && $stable(viol_lq_idx))); // R5

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && viol_read) |=> !viol_valid); // R6

    AST_LQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ld_count <= LQ_CNT_W'(LQ_DEPTH - 1)); // R1

    AST_SQUASH_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> (ld_count <= $past(ld_count))); // R9

    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        free_entries <= FREE_W'(LQ_DEPTH - 1)); // R11

endmodule

bind lq_order_unit lq_order_unit_chk #(
    .LQ_DEPTH (LQ_DEPTH),
    .LQ_IDX_W (LQ_IDX_W),
    .LQ_CNT_W (LQ_CNT_W),
    .FREE_W   (FREE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_exec_fault (st_exec_fault),
    .viol_read     (viol_read),
    .viol_valid    (viol_valid),
    .viol_lq_idx   (viol_lq_idx),
    .squash_valid  (squash_valid),
    .ld_count      (ld_count),
    .free_entries  (free_entries)
);

// File: tb/tb_lq_order_unit.sv
// Sweeping bench for lq_order_unit at its default configuration
// (8-entry queues, 16-bit addresses, 8-bit sequence numbers).
module tb_lq_order_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_ins_valid, st_ins_valid, st_release;
    logic [7:0]  ld_ins_seq;
    logic        ld_ins_ok, ld_ins_sq_none, st_ins_ok;
    logic [2:0]  ld_ins_lq_idx, ld_ins_sq_idx, st_ins_sq_idx, st_ins_lq_idx;
    logic        ld_exec_valid, st_exec_valid, st_exec_fault;
    logic [2:0]  ld_exec_idx, st_exec_lq_idx;
    logic [15:0] ld_exec_addr, st_exec_addr;
    logic        viol_read, viol_valid;
    logic [2:0]  viol_lq_idx;
    logic [7:0]  viol_seq;
    logic        commit_valid, squash_valid, stall_set, blk_set;
    logic [7:0]  commit_seq, squash_seq, blk_seq;
    logic [2:0]  stall_lq_idx;
    logic        stalled, blocked;
    logic [3:0]  ld_count, st_count, free_entries;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lq_order_unit dut (
        .clk(clk), .rst_n(rst_n),
        .ld_ins_valid(ld_ins_valid), .ld_ins_seq(ld_ins_seq), .ld_ins_ok(ld_ins_ok),
        .ld_ins_lq_idx(ld_ins_lq_idx), .ld_ins_sq_idx(ld_ins_sq_idx),
        .ld_ins_sq_none(ld_ins_sq_none),
        .st_ins_valid(st_ins_valid), .st_ins_ok(st_ins_ok),
        .st_ins_sq_idx(st_ins_sq_idx), .st_ins_lq_idx(st_ins_lq_idx),
        .st_release(st_release),
        .ld_exec_valid(ld_exec_valid), .ld_exec_idx(ld_exec_idx), .ld_exec_addr(ld_exec_addr),
        .st_exec_valid(st_exec_valid), .st_exec_lq_idx(st_exec_lq_idx),
        .st_exec_addr(st_exec_addr), .st_exec_fault(st_exec_fault),
        .viol_read(viol_read), .viol_valid(viol_valid), .viol_lq_idx(viol_lq_idx),
        .viol_seq(viol_seq),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .stall_set(stall_set), .stall_lq_idx(stall_lq_idx), .stalled(stalled),
        .blk_set(blk_set), .blk_seq(blk_seq), .blocked(blocked),
        .ld_count(ld_count), .st_count(st_count), .free_entries(free_entries)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        ld_ins_valid = 1'b0; ld_ins_seq = '0; st_ins_valid = 1'b0; st_release = 1'b0;
        ld_exec_valid = 1'b0; ld_exec_idx = '0; ld_exec_addr = '0;
        st_exec_valid = 1'b0; st_exec_lq_idx = '0; st_exec_addr = '0;
        viol_read = 1'b0; commit_valid = 1'b0; commit_seq = '0;
        squash_valid = 1'b0; squash_seq = '0;
        stall_set = 1'b0; stall_lq_idx = '0; blk_set = 1'b0; blk_seq = '0;
    endtask

    // One rising edge, return at the next falling edge with inputs idle.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
    endtask

    task automatic ins_load(input int seq);
        ld_ins_valid = 1'b1;
        ld_ins_seq = 8'(seq);
        step();
    endtask

    task automatic exec_load(input int idx, input int addr);
        ld_exec_valid = 1'b1;
        ld_exec_idx = 3'(idx);
        ld_exec_addr = 16'(addr);
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        @(negedge clk);
        do_reset();

        // R12: reset state
        chk("R12 ld_count", int'(ld_count), 0);
        chk("R12 st_count", int'(st_count), 0);
        chk("R12 viol_valid", int'(viol_valid), 0);
        chk("R12 stalled", int'(stalled), 0);
        chk("R12 blocked", int'(blocked), 0);
        chk("R12 free", int'(free_entries), 7);
        chk("R12 tail", int'(ld_ins_lq_idx), 0);

        // R1/R2: recorded positions
        ld_ins_valid = 1'b1; ld_ins_seq = 8'd1; #1;
        chk("R1 sq_none empty", int'(ld_ins_sq_none), 1);
        chk("R1 lq idx", int'(ld_ins_lq_idx), 0);
        step();
        st_ins_valid = 1'b1; #1;
        chk("R2 st lq idx", int'(st_ins_lq_idx), 1);
        step();
        st_ins_valid = 1'b1; step();
        ld_ins_valid = 1'b1; ld_ins_seq = 8'd2; #1;
        chk("R1 sq_none", int'(ld_ins_sq_none), 0);
        chk("R1 sq idx", int'(ld_ins_sq_idx), 2);
        chk("R1 lq idx 2nd", int'(ld_ins_lq_idx), 1);
        step();
        st_release = 1'b1; step();
        chk("R2 release", int'(st_count), 1);
        chk("R1 count", int'(ld_count), 2);

        // R11/R1/R2: occupancy sweep over both queues
        for (int a = 0; a <= 8; a++) begin
            for (int b = 0; b <= 8; b++) begin
                do_reset();
                for (int i = 0; i < ((a > b) ? a : b); i++) begin
                    ld_ins_valid = (i < a);
                    ld_ins_seq = 8'(i + 1);
                    st_ins_valid = (i < b);
                    step();
                end
                begin
                    int ea, eb, fa, fb;
                    ea = (a > 7) ? 7 : a;
                    eb = (b > 7) ? 7 : b;
                    fa = 8 - ea; fb = 8 - eb;
                    chk("R1 fill count", int'(ld_count), ea);
                    chk("R2 fill count", int'(st_count), eb);
                    chk("R11 free", int'(free_entries), ((fa < fb) ? fa : fb) - 1);
                end
            end
        end

        // R3..R7: violation sweep over wrap offset and younger-load states
        for (int o = 0; o < 8; o++) begin
            for (int pat = 0; pat < 81; pat++) begin
                int s, p, first, oslot;
                do_reset();
                for (int i = 0; i < o; i++) ins_load(i + 1);
                if (o > 0) begin
                    commit_valid = 1'b1; commit_seq = 8'(o); step();
                end
                oslot = o % 8;
                ins_load(o + 1);
                st_ins_valid = 1'b1; #1;
                s = int'(st_ins_lq_idx);
                if (pat == 0) chk("R2 store records tail", s, (o + 1) % 8);
                step();
                for (int j = 0; j < 4; j++) ins_load(o + 2 + j);
                exec_load(oslot, 16'h34FF);
                p = pat;
                first = -1;
                for (int j = 0; j < 4; j++) begin
                    int st, slot;
                    st = p % 3;
                    p = p / 3;
                    slot = (o + 1 + j) % 8;
                    if (st == 0) exec_load(slot, (j % 2 == 0) ? 16'h3500 + j : 16'h33FF - j);
                    else if (st == 1) begin
                        exec_load(slot, 16'h3400 + j * 16'h3F);
                        if (first < 0) first = j;
                    end
                end
                st_exec_valid = 1'b1; st_exec_lq_idx = 3'(s); st_exec_addr = 16'h3400; #1;
                chk("R3 fault", int'(st_exec_fault), (first >= 0) ? 1 : 0);
                step();
                chk("R4 viol_valid", int'(viol_valid), (first >= 0) ? 1 : 0);
                if (first >= 0) begin
                    chk("R4 viol idx", int'(viol_lq_idx), (o + 1 + first) % 8);
                    chk("R4 viol seq", int'(viol_seq), o + 2 + first);
                    st_exec_valid = 1'b1; st_exec_lq_idx = 3'(oslot); st_exec_addr = 16'h3400; #1;
                    chk("R5 no fault while held", int'(st_exec_fault), 0);
                    step();
                    chk("R5 idx held", int'(viol_lq_idx), (o + 1 + first) % 8);
                    viol_read = 1'b1; #1;
                    chk("R6 visible on read", int'(viol_valid), 1);
                    step();
                    chk("R6 cleared", int'(viol_valid), 0);
                end else begin
                    // R7: range widened to the older load proves it would match
                    st_exec_valid = 1'b1; st_exec_lq_idx = 3'(oslot); st_exec_addr = 16'h3400; #1;
                    chk("R7 older in range hits", int'(st_exec_fault), 1);
                    step();
                    chk("R7 older idx", int'(viol_lq_idx), oslot);
                end
            end
        end
        do_reset();
        chk("R12 viol after reset", int'(viol_valid), 0);

        // R8: commit runs with a concurrent insert
        for (int c = 0; c <= 6; c++) begin
            do_reset();
            for (int i = 1; i <= 5; i++) ins_load(i);
            commit_valid = 1'b1; commit_seq = 8'(c);
            ld_ins_valid = 1'b1; ld_ins_seq = 8'd6;
            step();
            chk("R8 count after commit", int'(ld_count), 6 - ((c > 5) ? 5 : c));
        end

        // R9/R10: squash runs with stall and blocked records
        for (int s = 0; s <= 6; s++) begin
            for (int k = 0; k < 6; k++) begin
                do_reset();
                for (int i = 1; i <= 6; i++) ins_load(i);
                stall_set = 1'b1; stall_lq_idx = 3'(k); blk_set = 1'b1; blk_seq = 8'd3;
                step();
                squash_valid = 1'b1; squash_seq = 8'(s);
                ld_ins_valid = 1'b1; ld_ins_seq = 8'd50;
                commit_valid = 1'b1; commit_seq = 8'd6;
                #1;
                chk("R9 insert refused", int'(ld_ins_ok), 0);
                step();
                chk("R9 count", int'(ld_count), s);
                chk("R10 stalled", int'(stalled), (k < s) ? 1 : 0);
                chk("R10 blocked", int'(blocked), (s < 3) ? 0 : 1);
                #1;
                chk("R9 tail", int'(ld_ins_lq_idx), s);
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule